// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Add-One Correction

This block is a purely combinational binary adder. It adds two N-bit operands and a one-bit carry-in, and it produces an N-bit sum and a carry-out. The operand width is cut into slices whose widths grow from the least significant end. The lowest slice is a plain ripple adder fed by the external carry-in. Every higher slice adds its bits once, with an assumed incoming carry of zero. It then forms the result for an incoming carry of one by incrementing the zero-case sum, instead of running a second ripple adder. The real carry leaving the slice below picks one of the two candidates.

The slice widths are 2, 2, 3, 4, 5 from the bottom for the default 16 bits. Each slice above the second is one bit wider than the slice below it. The top slice is cut short where the operand ends, so any N is valid. The widening is there so that the local sum of a slice is ready at about the time its select carry arrives. The block sits in arithmetic datapaths wherever a fast, compact add of two words is needed. It has no clock, no state and no control inputs.

Top module: `sqrt_csel_adder`

## Requirements
- R1: For every a, b and cin, the value {cout, sum} equals the (N+1)-bit arithmetic value a + b + cin, with a and b treated as unsigned.
- R2: The slices cover bits [1:0], [3:2], [6:4], [10:7] and [15:11] for N = 16. Each slice above the second is one bit wider than the one below it, and the top slice is cut short at bit N-1, so widths other than 16 (for example 4 and 32) also meet R1.
- R3: The carry-one candidate of a slice equals its carry-zero candidate plus one. This includes the case where the zero-case sum bits are all ones: the sum bits then wrap to zero and the candidate carry becomes one. A slice never yields both a carry-zero carry of one and an all-ones carry-zero sum.
- R4: A carry produced in the lowest bits propagates through every slice selection. For example, an operand of all ones plus cin = 1 gives sum 0 and cout 1, and an operand whose low k+1 bits are ones, plus cin = 1, clears exactly those bits and sets bit k+1.
- R5: cout is the carry selected for the most significant slice. It is 1 exactly when a + b + cin is at least 2^N.
- R6: With a and b held fixed, raising cin from 0 to 1 raises {cout, sum} by exactly one.
- R7: With all inputs at zero, sum and cout are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First unsigned operand |
| b | input | N | Second unsigned operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | N | Low N bits of a + b + cin |
| cout | output | 1 | Carry out of bit N-1 |

## Verification
Two functions can fall in the same evaluation. The first is a slice's own overflow, where its zero-case sum is all ones and it must wrap through the increment. The second is the arrival of a select carry from below. The two together decide whether a carry must pass straight through a slice. The bench forces both at once: it uses operands with runs of ones that end at every bit position, combined with a carry-in. The result is judged against a + b + cin computed arithmetically in the bench. A small 4-bit instance is swept over all 512 input combinations, and 16-bit and 32-bit instances get directed boundary words plus random vectors.

// File: rtl/csa_pkg.sv
package csa_pkg;

    // Nominal width of slice i: 2, 2, 3, 4, 5, ...
    function automatic int grp_nom(input int i);
        return (i < 2) ? 2 : i + 1;
    endfunction

    // Lowest bit position covered by slice i
    function automatic int grp_lo(input int i);
        int acc;
        acc = 0;
        for (int j = 0; j < i; j++) acc += grp_nom(j);
        return acc;
    endfunction

    // Number of slices needed to cover n bits
    function automatic int grp_count(input int n);
        int g;
        g = 0;
        while (grp_lo(g) < n) g++;
        return g;
    endfunction

    // Actual width of slice i, top slice cut short at n
    function automatic int grp_w(input int i, input int n);
        int rem;
        rem = n - grp_lo(i);
        return (grp_nom(i) < rem) ? grp_nom(i) : rem;
    endfunction

endpackage

// File: rtl/csa_ripple.sv
module csa_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:0] cc;
    assign cc[0] = ci;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign s[i]    = a[i] ^ b[i] ^ cc[i];
        assign cc[i+1] = (a[i] & b[i]) | (cc[i] & (a[i] ^ b[i]));
    end

    assign co = cc[W];

    logic [W:0] chk;
    always_comb begin
        chk = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
        AST_RIPPLE_SUM: assert ({co, s} == chk) else $error("ripple slice mismatch"); // R1
    end
endmodule

// File: rtl/csa_add_one.sv
module csa_add_one #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] y
);
    for (genvar i = 0; i < W; i++) begin : g_inc
        if (i == 0) begin : g_lsb
            assign y[0] = ~x[0];
        end else begin : g_upper
            assign y[i] = x[i] ^ (&x[i-1:0]);
        end
    end

    always_comb begin
        AST_ADD_ONE: assert (y == x + W'(1)) else $error("increment mismatch"); // R3
    end
endmodule

// File: rtl/csa_group.sv
module csa_group #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sel,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W-1:0] s_zero;
    logic [W-1:0] s_one;
    logic         c_zero;
    logic         c_one;

    csa_ripple #(.W(W)) u_rca0 (
        .a  (a),
        .b  (b),
        .ci (1'b0),
        .s  (s_zero),
        .co (c_zero)
    );

    csa_add_one #(.W(W)) u_inc (
        .x (s_zero),
        .y (s_one)
    );

    assign c_one = c_zero | (&s_zero);

    assign s  = sel ? s_one : s_zero;
    assign co = sel ? c_one : c_zero;

    always_comb begin
        AST_NO_DOUBLE_CARRY: assert (!(c_zero && (&s_zero))) else $error("carry and all-ones sum together"); // R3
        AST_ONE_CAND: assert ({c_one, s_one} == {c_zero, s_zero} + (W+1)'(1)) else $error("carry-one candidate wrong"); // R3
    end
endmodule

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder
    import csa_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         cin,
    output logic [N-1:0] sum,
    output logic         cout
);
    localparam int NG = grp_count(N);

    logic [NG:0] gc;
    assign gc[0] = cin;

    for (genvar g = 0; g < NG; g++) begin : g_slice
        localparam int LO = grp_lo(g);
        localparam int W  = grp_w(g, N);
        if (g == 0) begin : g_base
            csa_ripple #(.W(W)) u_rca (
                .a  (a[LO +: W]),
                .b  (b[LO +: W]),
                .ci (gc[0]),
                .s  (sum[LO +: W]),
                .co (gc[1])
            );
        end else begin : g_sel
            csa_group #(.W(W)) u_grp (
                .a   (a[LO +: W]),
                .b   (b[LO +: W]),
                .sel (gc[g]),
                .s   (sum[LO +: W]),
                .co  (gc[g+1])
            );
        end
    end

    assign cout = gc[NG];

    logic [N:0] total;
    always_comb begin
        total = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin};
        AST_TOTAL_SUM: assert (sum == total[N-1:0]) else $error("sum mismatch"); // R1
        AST_CARRY_OUT: assert (cout == total[N]) else $error("carry-out mismatch"); // R5
    end
endmodule

// File: tb/tb_sqrt_csel_adder.sv
module tb_sqrt_csel_adder;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] a16, b16, s16;
    logic        c16, co16;
    logic [3:0]  a4, b4, s4;
    logic        c4, co4;
    logic [31:0] a32, b32, s32;
    logic        c32, co32;

    sqrt_csel_adder #(.N(16)) dut   (.a(a16), .b(b16), .cin(c16), .sum(s16), .cout(co16));
    sqrt_csel_adder #(.N(4))  dut4  (.a(a4),  .b(b4),  .cin(c4),  .sum(s4),  .cout(co4));
    sqrt_csel_adder #(.N(32)) dut32 (.a(a32), .b(b32), .cin(c32), .sum(s32), .cout(co32));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run16(input string req, input logic [15:0] x, input logic [15:0] y, input logic ci);
        logic [16:0] e;
        a16 = x; b16 = y; c16 = ci;
        @(negedge clk);
        e = {1'b0, x} + {1'b0, y} + {16'd0, ci};
        check(req, {47'd0, co16, s16}, {47'd0, e});
    endtask

    initial begin
        a16 = '0; b16 = '0; c16 = 1'b0;
        a4 = '0; b4 = '0; c4 = 1'b0;
        a32 = '0; b32 = '0; c32 = 1'b0;
        @(negedge clk);
        // R7: all-zero inputs
        check("R7", {47'd0, co16, s16}, 64'd0);

        // R4: runs of ones ending at every bit, plus carry-in
        for (int k = 0; k < 16; k++) begin
            run16("R4", 16'((32'd1 << (k + 1)) - 1), 16'd0, 1'b1);
            run16("R2", 16'(32'd1 << k), 16'(32'd1 << k), 1'b0);
        end
        run16("R4", 16'hFFFF, 16'h0000, 1'b1);
        check("R4", {47'd0, co16, s16}, {47'd0, 1'b1, 16'h0000});
        // R5: carry-out boundary
        run16("R5", 16'hFFFF, 16'hFFFF, 1'b1);
        run16("R5", 16'h8000, 16'h7FFF, 1'b0);
        run16("R5", 16'h8000, 16'h8000, 1'b0);
        // R3: slice with all-ones local sum meeting incoming carry
        run16("R3", 16'h0783, 16'h0001, 1'b0);
        run16("R3", 16'h7FF0, 16'h000F, 1'b1);

        // R6: cin raises result by exactly one
        for (int i = 0; i < 200; i++) begin
            logic [15:0] x, y;
            logic [16:0] r0;
            x = 16'($urandom); y = 16'($urandom);
            a16 = x; b16 = y; c16 = 1'b0;
            @(negedge clk);
            r0 = {co16, s16};
            c16 = 1'b1;
            @(negedge clk);
            check("R6", {47'd0, co16, s16}, {47'd0, r0 + 17'd1});
        end

        // R1: random 16-bit vectors
        for (int i = 0; i < 2000; i++)
            run16("R1", 16'($urandom), 16'($urandom), 1'($urandom));

        // R2: exhaustive sweep of the 4-bit instance
        for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++)
                for (int ci = 0; ci < 2; ci++) begin
                    a4 = 4'(x); b4 = 4'(y); c4 = 1'(ci);
                    @(negedge clk);
                    check("R2", {59'd0, co4, s4}, 64'(x + y + ci));
                end

        // R2: random 32-bit vectors plus the full-carry corner
        for (int i = 0; i < 2000; i++) begin
            logic [32:0] e;
            a32 = $urandom; b32 = $urandom; c32 = 1'($urandom);
            if (i == 0) begin a32 = 32'hFFFF_FFFF; b32 = '0; c32 = 1'b1; end
            @(negedge clk);
            e = {1'b0, a32} + {1'b0, b32} + {32'd0, c32};
            check("R2", {31'd0, co32, s32}, {31'd0, e});
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int t = 0; t < 150000; t++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule